// File: doc/BRIEF.md
# Block-Count Word Sequencer with Transmit and Receive Queues

This block sits between a simple register bus and a word-level serial shift engine. Software preloads outgoing words into a small transmit queue. It then writes a control word that holds the number of words minus one, the two direction enables and the two completion-interrupt enables, with the run bit set. The sequencer hands words to the shift engine one at a time through a request/acknowledge handshake. Each word that comes back is pushed into a receive queue of the same depth. When the last word has been acknowledged, the block drops busy, sets a sticky ready flag and, if either completion interrupt is enabled, holds its interrupt line high.

The sequencer waits and drops nothing. It will not start a word while the receive queue is full with receive enabled, or while the transmit queue is empty with transmit enabled. Misuse of the queues is flagged with sticky bits: a push into a full transmit queue, or a pop from an empty receive queue. Ready and both error flags are cleared by writing one to their bit positions.

Top module: `bseq_top`

## Requirements
- R1: After reset the status word (address 1) reads 0x50 (transmit-empty bit 4 and receive-empty bit 6 set, everything else clear), the interrupt is low and no engine request is pending.
- R2: The transmit queue holds 4 words and transmit-full (status bit 5) is set when it does. A write to the transmit data port (address 2) while full is dropped and sets transmit-overflow (status bit 2).
- R3: A read of the receive data port (address 3) while the receive queue is empty returns 0 and sets receive-underflow (status bit 3).
- R4: Status bits 1 (ready), 2 and 3 clear when a one is written to them at address 1. Writing zero leaves them set.
- R5: Writing the control word (address 0) with bit 0 set starts a block of count+1 words, where count sits in bits 31:16. Busy (status bit 0, also read back as control bit 0) rises on the next cycle. Exactly count+1 requests follow, each carrying the transmit-queue words in write order, and eng_req and eng_tx_data stay stable until eng_ack.
- R6: After the last acknowledge, busy and control bit 0 fall and ready (status bit 1) is set.
- R7: irq is high exactly while ready is set and at least one of control bit 3 (transmit-complete enable) or bit 4 (receive-complete enable) is set.
- R8: With receive enabled (control bit 2), each acknowledged eng_rx_data word enters the receive queue in order. With it clear, nothing is stored.
- R9: With receive enabled and the receive queue full (status bit 7), no new request is raised until software reads a word. The block then finishes normally.
- R10: With transmit enabled (control bit 1), the sequencer waits for data while the transmit queue is empty. With it clear, it sends all-zero words and leaves the transmit queue untouched.
- R11: Writing status bit 8 empties the transmit queue and bit 9 empties the receive queue. Both requests are ignored while busy.
- R12: Control writes while busy change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at address 3) |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 transmit data, 3 receive data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level completion interrupt |
| eng_req | output | 1 | Word request to the shift engine |
| eng_tx_data | output | 32 | Word to shift out, valid with eng_req |
| eng_ack | input | 1 | Engine finished the word (one cycle) |
| eng_rx_data | input | 32 | Word shifted in, valid with eng_ack |

## Verification
The bench targets the queue boundaries. A fifth transmit write must be lost. An off-by-one depth would send it as the fourth word or flag no overflow. A 6-word receive block with no reads must stop at exactly four requests. A design that ignored the full flag would overwrite or lose words, and one that stalled early would stop short. It also starves the transmit queue mid-block, flushes and rewrites control while busy, and checks that the count field yields count+1 words, not count. A level interrupt that was actually a pulse, or that ignored the enable bits, is caught by sampling irq long after completion and after toggling the enables.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;
  localparam logic [1:0] A_RXD  = 2'd3;

  // control word bit positions
  localparam int C_RUN     = 0;
  localparam int C_TXEN    = 1;
  localparam int C_RXEN    = 2;
  localparam int C_IETX    = 3;
  localparam int C_IERX    = 4;
  localparam int C_CNT_LSB = 16;

  // status word bit positions
  localparam int S_BUSY  = 0;
  localparam int S_RDY   = 1;
  localparam int S_TXOVF = 2;
  localparam int S_RXUNF = 3;
  localparam int S_TXE   = 4;
  localparam int S_TXF   = 5;
  localparam int S_RXE   = 6;
  localparam int S_RXF   = 7;
  localparam int S_TXFL  = 8;
  localparam int S_RXFL  = 9;

  typedef struct packed {
    logic [CNT_W-1:0] count_m1;
    logic             ie_rx;
    logic             ie_tx;
    logic             rx_en;
    logic             tx_en;
  } ctrl_t;
endpackage

// File: rtl/bseq_fifo.sv
module bseq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULLC);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign dout_o  = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  // R2: the owner never pushes into a full queue; overflow is handled upstream
  a_r2_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R11: a flush leaves the queue empty
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty_o);
endmodule

// File: rtl/bseq_core.sv
module bseq_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CNT_W-1:0] count_m1_i,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             tx_empty_i,
  input  logic             rx_full_i,
  input  logic             eng_ack_i,
  output logic             busy_o,
  output logic             eng_req_o,
  output logic             word_done_o,
  output logic             done_o
);
  logic             busy_q, busy_d;
  logic             req_q, req_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             can_issue;

  assign word_done_o = req_q & eng_ack_i;
  assign done_o      = word_done_o & (rem_q == '0);
  assign can_issue   = busy_q & ~req_q & (~tx_en_i | ~tx_empty_i) & (~rx_en_i | ~rx_full_i);
  assign busy_o      = busy_q;
  assign eng_req_o   = req_q;

  always_comb begin
    busy_d = busy_q;
    req_d  = req_q;
    rem_d  = rem_q;
    if (go_i && !busy_q) begin
      busy_d = 1'b1;
      rem_d  = count_m1_i;
    end else if (can_issue) begin
      req_d = 1'b1;
    end else if (word_done_o) begin
      req_d = 1'b0;
      if (rem_q == '0) busy_d = 1'b0;
      else             rem_d  = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      rem_q  <= rem_d;
    end
  end

  // R6: completing the last word ends the block
  a_r6_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R5: requests only inside a running block
  a_r5_req_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req_o |-> busy_o);
  // R9: a word in flight always has room in the receive queue
  a_r9_room_for_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && rx_en_i) |-> !rx_full_i);
  // R10: a word in flight always has transmit data behind it
  a_r10_tx_backed: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && tx_en_i) |-> !tx_empty_i);
endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic              eng_req,
  output logic [WORD_W-1:0] eng_tx_data,
  input  logic              eng_ack,
  input  logic [WORD_W-1:0] eng_rx_data
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ready_q, ready_d, ovf_q, ovf_d, unf_q, unf_d;
  logic  wr_ctrl, wr_stat, wr_tx, rd_rx;
  logic  busy, go, word_done, done;
  logic  tx_empty, tx_full, rx_empty, rx_full;
  logic  tx_flush, rx_flush, tx_push, tx_pop, rx_push, rx_pop;
  logic [WORD_W-1:0] tx_dout, rx_dout, stat_w, ctrl_w;

  assign wr_ctrl = bus_wr & (bus_addr == A_CTRL);
  assign wr_stat = bus_wr & (bus_addr == A_STAT);
  assign wr_tx   = bus_wr & (bus_addr == A_TXD);
  assign rd_rx   = bus_rd & (bus_addr == A_RXD);
  assign go      = wr_ctrl & bus_wdata[C_RUN] & ~busy;

  assign tx_flush = wr_stat & bus_wdata[S_TXFL] & ~busy;
  assign rx_flush = wr_stat & bus_wdata[S_RXFL] & ~busy;
  assign tx_push  = wr_tx & ~tx_full;
  assign tx_pop   = word_done & ctrl_q.tx_en;
  assign rx_push  = word_done & ctrl_q.rx_en;
  assign rx_pop   = rd_rx & ~rx_empty;

  bseq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n), .flush_i(tx_flush), .push_i(tx_push), .din_i(bus_wdata),
    .pop_i(tx_pop), .dout_o(tx_dout), .empty_o(tx_empty), .full_o(tx_full));

  bseq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n), .flush_i(rx_flush), .push_i(rx_push), .din_i(eng_rx_data),
    .pop_i(rx_pop), .dout_o(rx_dout), .empty_o(rx_empty), .full_o(rx_full));

  bseq_core #(.CNT_W(CNT_W)) i_core (
    .clk(clk), .rst_n(rst_n), .go_i(go), .count_m1_i(bus_wdata[C_CNT_LSB +: CNT_W]),
    .tx_en_i(ctrl_q.tx_en), .rx_en_i(ctrl_q.rx_en), .tx_empty_i(tx_empty),
    .rx_full_i(rx_full), .eng_ack_i(eng_ack), .busy_o(busy), .eng_req_o(eng_req),
    .word_done_o(word_done), .done_o(done));

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl && !busy) begin
      ctrl_d.tx_en    = bus_wdata[C_TXEN];
      ctrl_d.rx_en    = bus_wdata[C_RXEN];
      ctrl_d.ie_tx    = bus_wdata[C_IETX];
      ctrl_d.ie_rx    = bus_wdata[C_IERX];
      ctrl_d.count_m1 = bus_wdata[C_CNT_LSB +: CNT_W];
    end
    ready_d = done | (ready_q & ~(wr_stat & bus_wdata[S_RDY]));
    ovf_d   = (wr_tx & tx_full) | (ovf_q & ~(wr_stat & bus_wdata[S_TXOVF]));
    unf_d   = (rd_rx & rx_empty) | (unf_q & ~(wr_stat & bus_wdata[S_RXUNF]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ready_q <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      ready_q <= ready_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  always_comb begin
    stat_w          = '0;
    stat_w[S_BUSY]  = busy;
    stat_w[S_RDY]   = ready_q;
    stat_w[S_TXOVF] = ovf_q;
    stat_w[S_RXUNF] = unf_q;
    stat_w[S_TXE]   = tx_empty;
    stat_w[S_TXF]   = tx_full;
    stat_w[S_RXE]   = rx_empty;
    stat_w[S_RXF]   = rx_full;
    ctrl_w          = '0;
    ctrl_w[C_RUN]   = busy;
    ctrl_w[C_TXEN]  = ctrl_q.tx_en;
    ctrl_w[C_RXEN]  = ctrl_q.rx_en;
    ctrl_w[C_IETX]  = ctrl_q.ie_tx;
    ctrl_w[C_IERX]  = ctrl_q.ie_rx;
    ctrl_w[C_CNT_LSB +: CNT_W] = ctrl_q.count_m1;
    unique case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_w;
      A_STAT:  bus_rdata = stat_w;
      A_TXD:   bus_rdata = '0;
      default: bus_rdata = rx_empty ? '0 : rx_dout;
    endcase
  end

  assign eng_tx_data = ctrl_q.tx_en ? tx_dout : '0;
  assign irq         = ready_q & (ctrl_q.ie_tx | ctrl_q.ie_rx);

  // R5: handshake stays stable until the engine acknowledges
  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_tx_data)));
  // R6: the end of a block always leaves ready set
  a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready_q);
  // R12: configuration is frozen while a block runs
  a_r12_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && busy) |=> $stable(ctrl_q));
endmodule

// File: tb/test_bseq_top.sv
`timescale 1ns/1ps
module test_bseq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, eng_req, eng_ack;
  logic [31:0] eng_tx_data, eng_rx_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] sent [0:255];
  int n_sent = 0;

  always #2.5 clk = ~clk;

  bseq_top i_bseq_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .eng_req(eng_req),
    .eng_tx_data(eng_tx_data), .eng_ack(eng_ack), .eng_rx_data(eng_rx_data));

  function automatic logic [31:0] exp_rx(int idx);
    return 32'hC0DE_0000 + 32'(idx);
  endfunction

  function automatic logic [31:0] ctrl_word(int cnt_m1, bit ierx, bit ietx, bit rxen, bit txen, bit run);
    return (32'(cnt_m1) << 16) | {27'd0, ierx, ietx, rxen, txen, run};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      bus_read(2'd1, s);
      if (!s[0]) break;
    end
  endtask

  // shift engine model: random latency, returns an indexed word
  initial begin
    int d;
    eng_ack = 1'b0;
    eng_rx_data = '0;
    forever begin
      @(negedge clk);
      if (eng_req && !eng_ack) begin
        d = $urandom_range(0, 2);
        repeat (d) @(negedge clk);
        sent[n_sent] = eng_tx_data;
        eng_rx_data = exp_rx(n_sent);
        n_sent++;
        eng_ack = 1'b1;
        @(negedge clk);
        eng_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] w [0:7];
    int base, c;
    void'($urandom(32'd1234));
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd1, r); check("R1 status", r, 32'h50);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 req", {31'd0, eng_req}, 0);

    // R2 depth and overflow
    for (int i = 0; i < 5; i++) begin w[i] = $urandom; bus_write(2'd2, w[i]); end
    bus_read(2'd1, r); check("R2 full+ovf", r, 32'h64);
    // R4 write-zero keeps, write-one clears
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, r); check("R4 w0 keeps", r, 32'h64);
    bus_write(2'd1, 32'h4);
    bus_read(2'd1, r); check("R4 w1 clears", r, 32'h60);

    // R5 R6 R7 R8 four-word full-duplex block
    base = n_sent;
    bus_write(2'd0, ctrl_word(3, 0, 1, 1, 1, 1));
    bus_read(2'd1, r); check("R5 busy", r & 32'h1, 32'h1);
    wait_idle();
    check("R5 count", 32'(n_sent - base), 4);
    for (int i = 0; i < 4; i++) check("R5 order R2 drop", sent[base+i], w[i]);
    bus_read(2'd1, r); check("R6 ready", r, 32'h92);
    check("R7 irq high", {31'd0, irq}, 1);
    bus_read(2'd0, r); check("R6 run clears", r, ctrl_word(3, 0, 1, 1, 1, 0));
    for (int i = 0; i < 4; i++) begin bus_read(2'd3, r); check("R8 rx data", r, exp_rx(base+i)); end
    bus_read(2'd3, r); check("R3 empty read data", r, 32'h0);
    bus_read(2'd1, r); check("R3 underflow", r, 32'h5A);
    bus_write(2'd1, 32'hA);
    bus_read(2'd1, r); check("R4 clear ready+unf", r, 32'h50);
    check("R7 irq low after clear", {31'd0, irq}, 0);

    // R10 R8 R7 no-direction block, no interrupt enables
    base = n_sent;
    bus_write(2'd0, ctrl_word(1, 0, 0, 0, 0, 1));
    wait_idle();
    check("R10 count", 32'(n_sent - base), 2);
    check("R10 zero word0", sent[base], 0);
    check("R10 zero word1", sent[base+1], 0);
    bus_read(2'd1, r); check("R8 nothing stored", r, 32'h52);
    check("R7 irq masked", {31'd0, irq}, 0);
    bus_write(2'd0, ctrl_word(1, 1, 0, 0, 0, 0));
    @(negedge clk); check("R7 irq level on enable", {31'd0, irq}, 1);
    bus_write(2'd1, 32'h2);
    @(negedge clk); check("R7 irq drops", {31'd0, irq}, 0);

    // R9 stall on full receive queue; R11 R12 while busy
    base = n_sent;
    bus_write(2'd0, ctrl_word(5, 0, 0, 1, 0, 1));
    repeat (40) @(negedge clk);
    check("R9 stalled count", 32'(n_sent - base), 4);
    bus_read(2'd1, r); check("R9 stalled status", r, 32'h91);
    check("R9 no req", {31'd0, eng_req}, 0);
    bus_write(2'd1, 32'h200);
    bus_read(2'd1, r); check("R11 flush ignored busy", r, 32'h91);
    bus_write(2'd0, ctrl_word(0, 1, 1, 1, 1, 1));
    bus_read(2'd0, r); check("R12 ctrl locked", r, ctrl_word(5, 0, 0, 1, 0, 1));
    for (int i = 0; i < 4; i++) begin bus_read(2'd3, r); check("R9 rx data", r, exp_rx(base+i)); end
    wait_idle();
    check("R9 finished count", 32'(n_sent - base), 6);
    for (int i = 4; i < 6; i++) begin bus_read(2'd3, r); check("R9 rx tail", r, exp_rx(base+i)); end
    bus_write(2'd1, 32'h2);

    // R10 transmit starvation
    base = n_sent;
    w[0] = $urandom; bus_write(2'd2, w[0]);
    bus_write(2'd0, ctrl_word(2, 0, 0, 0, 1, 1));
    repeat (30) @(negedge clk);
    check("R10 starved count", 32'(n_sent - base), 1);
    bus_read(2'd1, r); check("R10 starved busy", r & 32'h1, 32'h1);
    for (int i = 1; i < 3; i++) begin w[i] = $urandom; bus_write(2'd2, w[i]); end
    wait_idle();
    check("R10 resumed count", 32'(n_sent - base), 3);
    for (int i = 0; i < 3; i++) check("R10 resumed order", sent[base+i], w[i]);
    bus_write(2'd1, 32'h2);

    // R11 flushes when idle
    bus_write(2'd2, 32'h1111); bus_write(2'd2, 32'h2222);
    bus_read(2'd1, r); check("R11 tx loaded", r, 32'h40);
    bus_write(2'd1, 32'h100);
    bus_read(2'd1, r); check("R11 tx flushed", r, 32'h50);
    bus_write(2'd0, ctrl_word(1, 0, 0, 1, 0, 1));
    wait_idle();
    bus_read(2'd1, r); check("R11 rx loaded", r, 32'h12);
    bus_write(2'd1, 32'h202);
    bus_read(2'd1, r); check("R11 rx flushed", r, 32'h50);

    // random full-duplex blocks
    for (int k = 0; k < 6; k++) begin
      c = $urandom_range(0, 3);
      for (int i = 0; i <= c; i++) begin w[i] = $urandom; bus_write(2'd2, w[i]); end
      base = n_sent;
      bus_write(2'd0, ctrl_word(c, 1, 0, 1, 1, 1));
      wait_idle();
      check("R5 random count", 32'(n_sent - base), 32'(c + 1));
      for (int i = 0; i <= c; i++) check("R5 random tx", sent[base+i], w[i]);
      for (int i = 0; i <= c; i++) begin bus_read(2'd3, r); check("R8 random rx", r, exp_rx(base+i)); end
      check("R7 random irq", {31'd0, irq}, 1);
      bus_write(2'd1, 32'h2);
      bus_read(2'd1, r); check("R6 random idle", r, 32'h50);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule